// File: doc/BRIEF.md
# Interrupt Flag and Wake-Up Controller

This block collects the three interrupt sources of a small 8-bit controller core: a timer overflow strobe, a port input-change strobe, and an asynchronous external interrupt pin. It records each event in a pending-flag register and keeps a separate mask register. The external pin is synchronised with two flip-flops, and a falling edge after the synchronizer counts as an event. The timer and port sources arrive as one-cycle strobes that the timer and port logic have already edge-qualified.

The core sees a request line and a fixed interrupt vector. It has strobes to set and to clear the global interrupt enable, and a strobe that says it has taken the request. Software can read and write the flag and mask registers. Software writes can only clear flags. A flag read returns only the unmasked flags.

A sleep strobe parks the block in a sleep state. The first enabled pending flag ends the sleep with a one-cycle wake pulse. A resume-target output then tells the core where to continue. The target is the interrupt vector if the global enable was on when the core went to sleep. Otherwise it is the instruction after the sleep instruction.

Top module: `irq_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first falling clock edge after it rises, the reset state holds: `flag_rd_data` = 0, `mask_rd_data` = 0, the global enable is off, `irq_req` = 0, `wake_o` = 0, `asleep_o` = 0 and `resume_to_vector` = 0.
- R2: A hardware event sets its flag at the next rising clock edge. The timer strobe sets flag bit 0, the port-change strobe sets bit 1 and the external-pin edge sets bit 2. Bits 7 to 3 of `flag_rd_data` always read 0.
- R3: A software flag write leaves each flag as the AND of its old value and the written data bit. Writing 0 to a bit clears it. Writing 1 keeps it. A software write never sets a flag.
- R4: If a hardware event and a software clear hit the same flag bit in the same cycle, the flag ends up set.
- R5: `flag_rd_data` equals the flags ANDed with the mask. A mask write stores bits 2:0 of the written data. `mask_rd_data` returns them, with bits 7 to 3 reading 0.
- R6: A falling edge on `ext_pin` sets flag bit 2 at the third rising clock edge after the edge. A rising edge on `ext_pin` sets nothing.
- R7: `irq_req` is 1 exactly when the global enable is on and at least one flag ANDed with its mask bit is 1. `gie_set` turns the global enable on. `gie_clr` and `irq_take` turn it off. A clear beats a set in the same cycle.
- R8: `irq_vector` is always 0x008.
- R9: After `sleep_enter`, `asleep_o` is 1. At the first rising clock edge that sees an enabled pending flag, `asleep_o` drops and `wake_o` pulses high for exactly one cycle.
- R10: Each `sleep_enter` loads `resume_to_vector` with the global enable at that moment. The value is 1 for the vector and 0 for the next instruction, and it holds until the next `sleep_enter`.
- R11: A one-cycle `wdt_rst` pulse returns every register to the R1 reset state at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset: power-on or reset pin |
| wdt_rst | input | 1 | Synchronous watchdog time-out reset strobe |
| tmr_ovf_evt | input | 1 | Timer overflow event strobe |
| port_chg_evt | input | 1 | Port input-change event strobe |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| flag_wr_en | input | 1 | Flag register write strobe |
| flag_wr_data | input | 8 | Flag write data: a 0 bit clears that flag |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 8 | Mask write data |
| flag_rd_data | output | 8 | Flags ANDed with the mask |
| mask_rd_data | output | 8 | Mask register contents |
| gie_set | input | 1 | Global interrupt enable set strobe |
| gie_clr | input | 1 | Global interrupt enable clear strobe |
| irq_take | input | 1 | The core accepts the request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 10 | Interrupt vector address |
| sleep_enter | input | 1 | The sleep instruction has executed |
| asleep_o | output | 1 | The block is in the sleep state |
| wake_o | output | 1 | One-cycle wake pulse |
| resume_to_vector | output | 1 | 1: resume at the vector, 0: resume after the sleep instruction |

## Verification
The assertions assume that each event strobe lasts one cycle and that the input strobes change only between clock edges. They also assume `wdt_rst` is a single-cycle pulse. The bench drives every input just after the falling edge, and it holds `ext_pin` steady for several cycles around each edge it makes. The random phase drives `ext_pin` high and never enters sleep. Pin-edge timing and the sleep and wake sequences are covered only by directed cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_TMR  = 0;
  localparam int SRC_PORT = 1;
  localparam int SRC_EXT  = 2;

  typedef enum logic {PWR_RUN = 1'b0, PWR_SLEEP = 1'b1} pwr_state_t;
endpackage

// File: rtl/irq_ext_edge.sv
module irq_ext_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else if (soft_rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] set_i,
  input  logic         wr_en,
  input  logic [N-1:0] wr_keep,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flags_o[i] <= 1'b0;
      else if (soft_rst)             flags_o[i] <= 1'b0;
      else if (set_i[i])             flags_o[i] <= 1'b1;
      else if (wr_en && !wr_keep[i]) flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_power_ctl.sv
module irq_power_ctl
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic sleep_enter,
  input  logic pending,
  input  logic gie,
  output logic asleep_o,
  output logic wake_o,
  output logic resume_vec_o
);
  pwr_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= PWR_RUN;
      wake_o       <= 1'b0;
      resume_vec_o <= 1'b0;
    end else if (soft_rst) begin
      state_q      <= PWR_RUN;
      wake_o       <= 1'b0;
      resume_vec_o <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      unique case (state_q)
        PWR_RUN: if (sleep_enter) begin
          state_q      <= PWR_SLEEP;
          resume_vec_o <= gie;
        end
        PWR_SLEEP: if (pending) begin
          state_q <= PWR_RUN;
          wake_o  <= 1'b1;
        end
        default: state_q <= PWR_RUN;
      endcase
    end
  end

  assign asleep_o = (state_q == PWR_SLEEP);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_pkg::*;
#(
  parameter int          REG_W     = 8,
  parameter int          PC_W      = 10,
  parameter int          SYNC_STG  = 2,
  parameter logic [9:0]  VEC_ADDR  = 10'h008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_rst,
  input  logic             tmr_ovf_evt,
  input  logic             port_chg_evt,
  input  logic             ext_pin,
  input  logic             flag_wr_en,
  input  logic [REG_W-1:0] flag_wr_data,
  input  logic             mask_wr_en,
  input  logic [REG_W-1:0] mask_wr_data,
  output logic [REG_W-1:0] flag_rd_data,
  output logic [REG_W-1:0] mask_rd_data,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             irq_take,
  output logic             irq_req,
  output logic [PC_W-1:0]  irq_vector,
  input  logic             sleep_enter,
  output logic             asleep_o,
  output logic             wake_o,
  output logic             resume_to_vector
);
  localparam int PAD_W = REG_W - NUM_SRC;

  logic               ext_fall;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] enabled;
  logic               gie_q;
  logic               pending;

  irq_ext_edge #(.STAGES(SYNC_STG)) u_edge (
    .clk(clk), .rst_n(rst_n), .soft_rst(wdt_rst),
    .pin_i(ext_pin), .fall_o(ext_fall)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_TMR]  = tmr_ovf_evt;
    set_vec[SRC_PORT] = port_chg_evt;
    set_vec[SRC_EXT]  = ext_fall;
  end

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(wdt_rst),
    .set_i(set_vec), .wr_en(flag_wr_en),
    .wr_keep(flag_wr_data[NUM_SRC-1:0]), .flags_o(flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else if (wdt_rst) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (mask_wr_en) mask_q <= mask_wr_data[NUM_SRC-1:0];
      if (gie_clr || irq_take) gie_q <= 1'b0;
      else if (gie_set)        gie_q <= 1'b1;
    end
  end

  assign enabled      = flags_q & mask_q;
  assign pending      = |enabled;
  assign flag_rd_data = {{PAD_W{1'b0}}, enabled};
  assign mask_rd_data = {{PAD_W{1'b0}}, mask_q};
  assign irq_req      = gie_q & pending;
  assign irq_vector   = VEC_ADDR[PC_W-1:0];

  irq_power_ctl u_pwr (
    .clk(clk), .rst_n(rst_n), .soft_rst(wdt_rst),
    .sleep_enter(sleep_enter), .pending(pending), .gie(gie_q),
    .asleep_o(asleep_o), .wake_o(wake_o), .resume_vec_o(resume_to_vector)
  );
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wdt_rst,
  input logic       tmr_ovf_evt,
  input logic       port_chg_evt,
  input logic       ext_fall,
  input logic       flag_wr_en,
  input logic [2:0] flags_q,
  input logic       gie_q,
  input logic [7:0] flag_rd_data,
  input logic [7:0] mask_rd_data,
  input logic       irq_take,
  input logic       irq_req,
  input logic       wake_o
);
  assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !tmr_ovf_evt && !port_chg_evt && !ext_fall && !wdt_rst)
      |=> ((flags_q & ~$past(flags_q)) == 3'b000));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf_evt && !wdt_rst) |=> flags_q[0]);

  assert_read_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_data & ~mask_rd_data) == 8'h00);

  assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie_q && flag_rd_data != 8'h00));

  assert_take_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_req);

  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  assert_wdt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (flags_q == 3'b000 && !gie_q && !wake_o));
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst),
  .tmr_ovf_evt(tmr_ovf_evt), .port_chg_evt(port_chg_evt), .ext_fall(ext_fall),
  .flag_wr_en(flag_wr_en), .flags_q(flags_q), .gie_q(gie_q),
  .flag_rd_data(flag_rd_data), .mask_rd_data(mask_rd_data),
  .irq_take(irq_take), .irq_req(irq_req), .wake_o(wake_o)
);

// File: tb/irq_wake_ctrl_tb_top.sv
module irq_wake_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdt_rst = 1'b0;
  logic       tmr_ovf_evt = 1'b0, port_chg_evt = 1'b0, ext_pin = 1'b1;
  logic       flag_wr_en = 1'b0, mask_wr_en = 1'b0;
  logic [7:0] flag_wr_data = 8'h00, mask_wr_data = 8'h00;
  logic [7:0] flag_rd_data, mask_rd_data;
  logic       gie_set = 1'b0, gie_clr = 1'b0, irq_take = 1'b0;
  logic       irq_req, asleep_o, wake_o, resume_to_vector, sleep_enter = 1'b0;
  logic [9:0] irq_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst),
    .tmr_ovf_evt(tmr_ovf_evt), .port_chg_evt(port_chg_evt), .ext_pin(ext_pin),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .flag_rd_data(flag_rd_data), .mask_rd_data(mask_rd_data),
    .gie_set(gie_set), .gie_clr(gie_clr), .irq_take(irq_take),
    .irq_req(irq_req), .irq_vector(irq_vector),
    .sleep_enter(sleep_enter), .asleep_o(asleep_o), .wake_o(wake_o),
    .resume_to_vector(resume_to_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    tmr_ovf_evt = 0; port_chg_evt = 0; flag_wr_en = 0; mask_wr_en = 0;
    gie_set = 0; gie_clr = 0; irq_take = 0; sleep_enter = 0; wdt_rst = 0;
  endtask

  function automatic logic [2:0] next_flags(input logic [2:0] f, input logic wr,
                                            input logic [2:0] d, input logic [2:0] ev);
    return (wr ? (f & d) : f) | ev;
  endfunction

  function automatic logic next_gie(input logic g, input logic s, input logic c);
    return c ? 1'b0 : (s ? 1'b1 : g);
  endfunction

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] mf, mm, nf;
    logic       mg, ev_t, ev_p, wr, cl;
    logic [7:0] d;
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk);
    check("R1 flag rd in reset", flag_rd_data, 0);
    check("R1 req in reset", irq_req, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 flag rd", flag_rd_data, 0);
    check("R1 mask rd", mask_rd_data, 0);
    check("R1 irq_req", irq_req, 0);
    check("R1 wake/asleep/resume", {wake_o, asleep_o, resume_to_vector}, 0);
    check("R8 vector", irq_vector, 10'h008);

    mask_wr_en = 1; mask_wr_data = 8'hFF; cyc(); idle();
    check("R5 mask upper bits zero", mask_rd_data, 8'h07);
    tmr_ovf_evt = 1; cyc(); idle();
    check("R2 timer bit0", flag_rd_data, 8'h01);
    port_chg_evt = 1; cyc(); idle();
    check("R2 port bit1", flag_rd_data, 8'h03);
    flag_wr_en = 1; flag_wr_data = 8'hFE; cyc(); idle();
    check("R3 clear bit0 only", flag_rd_data, 8'h02);
    flag_wr_en = 1; flag_wr_data = 8'h00; cyc(); idle();
    check("R3 clear all", flag_rd_data, 8'h00);
    flag_wr_en = 1; flag_wr_data = 8'hFF; cyc(); idle();
    check("R3 write ones sets nothing", flag_rd_data, 8'h00);
    tmr_ovf_evt = 1; flag_wr_en = 1; flag_wr_data = 8'h00; cyc(); idle();
    check("R4 set beats clear", flag_rd_data, 8'h01);

    ext_pin = 0; cyc(); cyc();
    check("R6 ext not yet after two edges", flag_rd_data, 8'h01);
    cyc();
    check("R6 ext fall sets bit2", flag_rd_data, 8'h05);
    flag_wr_en = 1; flag_wr_data = 8'h00; cyc(); idle();
    ext_pin = 1; repeat (4) cyc();
    check("R6 rising edge ignored", flag_rd_data, 8'h00);

    mask_wr_en = 1; mask_wr_data = 8'h01; port_chg_evt = 1; gie_set = 1; cyc(); idle();
    check("R5 masked flag reads zero", flag_rd_data, 8'h00);
    check("R7 masked flag no request", irq_req, 0);
    mask_wr_en = 1; mask_wr_data = 8'h02; cyc(); idle();
    check("R5 unmasked reads", flag_rd_data, 8'h02);
    check("R7 request", irq_req, 1);
    irq_take = 1; cyc(); idle();
    check("R7 take clears enable", irq_req, 0);
    gie_set = 1; gie_clr = 1; cyc(); idle();
    check("R7 clear beats set", irq_req, 0);
    gie_set = 1; cyc(); idle();
    check("R7 set enable", irq_req, 1);

    flag_wr_en = 1; flag_wr_data = 8'h00; mask_wr_en = 1; mask_wr_data = 8'h07;
    sleep_enter = 1; cyc(); idle();
    check("R9 asleep", asleep_o, 1);
    check("R10 resume to vector", resume_to_vector, 1);
    cyc();
    check("R9 no wake without event", {asleep_o, wake_o}, 2'b10);
    tmr_ovf_evt = 1; cyc(); idle();
    check("R9 wake not yet", wake_o, 0);
    cyc();
    check("R9 wake pulse", {asleep_o, wake_o}, 2'b01);
    cyc();
    check("R9 wake one cycle", wake_o, 0);
    check("R10 resume holds", resume_to_vector, 1);

    gie_clr = 1; flag_wr_en = 1; flag_wr_data = 8'h00; cyc(); idle();
    sleep_enter = 1; cyc(); idle();
    check("R10 resume next instr", resume_to_vector, 0);
    port_chg_evt = 1; cyc(); idle(); cyc();
    check("R9 wake gie off", wake_o, 1);
    check("R7 no req gie off", irq_req, 0);

    gie_set = 1; tmr_ovf_evt = 1; cyc(); idle();
    wdt_rst = 1; cyc(); idle();
    check("R11 flags clear", flag_rd_data, 0);
    check("R11 mask clear", mask_rd_data, 0);
    check("R11 resume clear", {resume_to_vector, wake_o, asleep_o}, 0);
    mask_wr_en = 1; mask_wr_data = 8'h07; tmr_ovf_evt = 1; cyc(); idle();
    check("R11 enable cleared", irq_req, 0);
    wdt_rst = 1; cyc(); idle();

    mf = 0; mm = 0; mg = 0;
    for (int k = 0; k < 400; k++) begin
      ev_t = ($urandom_range(0, 3) == 0);
      ev_p = ($urandom_range(0, 3) == 0);
      wr   = ($urandom_range(0, 3) == 0);
      d    = 8'($urandom);
      tmr_ovf_evt = ev_t; port_chg_evt = ev_p;
      flag_wr_en = wr; flag_wr_data = d;
      mask_wr_en = ($urandom_range(0, 4) == 0); mask_wr_data = 8'($urandom);
      gie_set = ($urandom_range(0, 2) == 0);
      cl = ($urandom_range(0, 5) == 0);
      gie_clr = cl;
      irq_take = irq_req && ($urandom_range(0, 1) == 0);
      nf = next_flags(mf, wr, d[2:0], {1'b0, ev_p, ev_t});
      if (mask_wr_en) mm = mask_wr_data[2:0];
      mg = next_gie(mg, gie_set, cl || irq_take);
      mf = nf;
      cyc(); idle();
      check("R3 R4 R5 random flag read", flag_rd_data, {5'b0, mf & mm});
      check("R7 random request", irq_req, mg && ((mf & mm) != 0));
    end

    rst_n = 0; @(negedge clk);
    check("R1 async reset mid-run", {flag_rd_data, mask_rd_data, 7'b0, irq_req}, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule